// File: doc/BRIEF.md
# Four-Lane Serial Self-Test Controller

This unit runs a built-in self-test across the four lanes of a serial retimer. Software reaches it through a 16-bit register window. It writes a control word that picks one of four test patterns and the symbol width. It then arms the run in three separate writes: the configuration, then the enable bit, then the start bit. While the run is active, the same symbol stream goes out on every lane. The receive side compares each lane with the symbol sent in the same cycle; the loopback outside the block has zero latency. Traffic is grouped into fixed-length frames. The unit counts frames sent, and for each lane it counts frames received and frames that held at least one wrong symbol.

Setting the stop bit does not end the run at once. The generator and the checkers keep running for a fixed drain window so that the frame in flight is still counted. The stop bit reads back as 1 until the drain has finished and then clears itself. A run passes when every lane reports a nonzero frame count and a zero error count.

Top module: `lane_bist_ctrl`

## Requirements
- R1: The control word at address 0 holds the pattern select in bits 11:10 (0 incrementing, 1 and 2 fixed eight-entry tables, 3 pseudo-random), the wide-symbol flag in bit 12 (1 = 10-bit, 0 = 8-bit), enable in bit 13, stop in bit 14 and start in bit 15. Each field reads back as written, with bits 9:0 reading 0.
- R2: A write that sets start while the stored enable bit is 0 is ignored: no run begins and bit 15 reads 0.
- R3: Accepting start, which needs the stored enable at 1 and the unit idle, clears every counter and begins a run. Counters never decrease except at that clear.
- R4: A stop write during a run clears start at once. Bit 14 then reads 1 for exactly 8 cycles and returns to 0 after that.
- R5: Symbols keep flowing during the drain, and frames completed during the drain are counted. A run with N active cycles reports floor(N / 8) transmitted frames. The active cycles are the cycles from the clock after the start write through the end of the drain.
- R6: Counters read at address 1 (frames sent), addresses 2 to 5 (frames received, lanes 0 to 3) and addresses 6 to 9 (errored frames, lanes 0 to 3). Addresses 10 to 15 read 0.
- R7: A frame that holds any symbol mismatch on a lane adds exactly one to that lane's error count and leaves the other lanes' error counts unchanged.
- R8: In 8-bit mode, transmitted bits 9:8 are 0 and only received bits 7:0 are compared.
- R9: Counters saturate at all ones (0xFFFF at the default width) and never wrap.
- R10: The incrementing pattern sends 0 as the first symbol after start and adds 1 per symbol. All lanes carry the same symbol.
- R11: The pseudo-random pattern uses the polynomial x^7 + x^6 + 1 and starts from the all-ones state. It emits 10 new bits per symbol, the first bit generated going to bit 9, and the state carries over between symbols.
- R12: A control write with enable at 0 ends any run in the same cycle. The outputs go to 0 and the counters freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tx_data | output | 40 | Transmitted symbols, 10 bits per lane, lane 0 in the low bits |
| rx_data | input | 40 | Symbols received on the wrap, same layout |

## Verification
The assertions assume three things about the inputs. The received data returns in the same cycle it was sent. Software writes the control word with enable set whenever it intends a stop or start to be honoured. Counter widths are no wider than the register. The bench keeps within these limits: it closes the loop with a combinational XOR mask, it drives each control write for exactly one clock, and it builds the counters 6 bits wide so that saturation is reached in a few hundred cycles. Errors are injected only by toggling the mask between clock edges inside the active window, so each corrupted symbol lands in a known frame.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int SYM_W   = 10;
    localparam int REG_W   = 16;
    localparam int PRBS_W  = 7;

    localparam int B_TYPE_LO = 10;
    localparam int B_WIDE    = 12;
    localparam int B_EN      = 13;
    localparam int B_STOP    = 14;
    localparam int B_START   = 15;

    typedef enum logic [1:0] {
        PAT_INC  = 2'd0,
        PAT_TABA = 2'd1,
        PAT_TABB = 2'd2,
        PAT_PRBS = 2'd3
    } pat_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_st_t;

    typedef struct packed {
        pat_t pat;
        logic wide;
    } cfg_t;

    // first fixed table: alternating-density words
    function automatic logic [SYM_W-1:0] tab_a(input logic [2:0] i);
        case (i)
            3'd0: tab_a = 10'h17C;
            3'd1: tab_a = 10'h283;
            3'd2: tab_a = 10'h0AA;
            3'd3: tab_a = 10'h355;
            3'd4: tab_a = 10'h1F0;
            3'd5: tab_a = 10'h20F;
            3'd6: tab_a = 10'h0CC;
            default: tab_a = 10'h333;
        endcase
    endfunction

    // second fixed table: long-run words for jitter stress
    function automatic logic [SYM_W-1:0] tab_b(input logic [2:0] i);
        case (i)
            3'd0: tab_b = 10'h3E0;
            3'd1: tab_b = 10'h01F;
            3'd2: tab_b = 10'h3F8;
            3'd3: tab_b = 10'h007;
            3'd4: tab_b = 10'h0F5;
            3'd5: tab_b = 10'h30A;
            3'd6: tab_b = 10'h15E;
            default: tab_b = 10'h2A1;
        endcase
    endfunction

    // state after SYM_W shifts of x^7 + x^6 + 1
    function automatic logic [PRBS_W-1:0] prbs_adv(input logic [PRBS_W-1:0] s_in);
        logic [PRBS_W-1:0] s;
        s = s_in;
        for (int k = 0; k < SYM_W; k++) s = {s[PRBS_W-2:0], s[6] ^ s[5]};
        return s;
    endfunction

    // SYM_W new bits, first generated bit at the MSB
    function automatic logic [SYM_W-1:0] prbs_sym(input logic [PRBS_W-1:0] s_in);
        logic [PRBS_W-1:0] s;
        logic [SYM_W-1:0]  o;
        logic              nb;
        s = s_in;
        o = '0;
        for (int k = 0; k < SYM_W; k++) begin
            nb = s[6] ^ s[5];
            o[SYM_W-1-k] = nb;
            s = {s[PRBS_W-2:0], nb};
        end
        return o;
    endfunction

endpackage

// File: rtl/lbist_satcnt.sv
module lbist_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)               q <= '0;
        else if (inc && q != TOP)     q <= q + 1'b1;
    end

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (q == TOP && !clr) |=> (q == TOP));

    p_no_drop_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (q >= $past(q)));

endmodule

// File: rtl/lbist_regs.sv
module lbist_regs
    import lbist_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DRAIN_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output cfg_t              cfg,
    output logic              active,
    output logic              clr,
    output logic [REG_W-1:0]  ctrl_rd
);
    localparam int DW = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;

    run_st_t        state;
    logic           en_q;
    logic           start_q;
    logic [DW-1:0]  drain_cnt;
    logic           ctrl_wr, dis, stop_acc, start_acc;

    assign ctrl_wr   = reg_wr && (reg_addr == '0);
    assign dis       = ctrl_wr && !reg_wdata[B_EN];
    assign stop_acc  = ctrl_wr && reg_wdata[B_EN] && reg_wdata[B_STOP] && state == ST_RUN;
    assign start_acc = ctrl_wr && reg_wdata[B_EN] && reg_wdata[B_START]
                       && en_q && state == ST_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            en_q      <= 1'b0;
            start_q   <= 1'b0;
            state     <= ST_IDLE;
            drain_cnt <= '0;
        end else begin
            if (ctrl_wr) begin
                cfg.pat  <= pat_t'(reg_wdata[B_TYPE_LO +: 2]);
                cfg.wide <= reg_wdata[B_WIDE];
                en_q     <= reg_wdata[B_EN];
            end
            if (dis) begin
                state   <= ST_IDLE;
                start_q <= 1'b0;
            end else if (stop_acc) begin
                state     <= ST_DRAIN;
                start_q   <= 1'b0;
                drain_cnt <= DW'(DRAIN_CYC - 1);
            end else if (start_acc) begin
                state   <= ST_RUN;
                start_q <= 1'b1;
            end else if (state == ST_DRAIN) begin
                if (drain_cnt == '0) state <= ST_IDLE;
                else                 drain_cnt <= drain_cnt - 1'b1;
            end
        end
    end

    assign active  = (state != ST_IDLE);
    assign clr     = start_acc;
    assign ctrl_rd = {start_q, state == ST_DRAIN, en_q, cfg.wide, cfg.pat, 10'b0};

    p_start_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[B_START] && !en_q) |=> !start_q);

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && drain_cnt != '0 && !dis) |=> (state == ST_DRAIN));

    p_drain_no_start_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> !start_q);

    p_disable_idle_r12: assert property (@(posedge clk) disable iff (rst)
        dis |=> !active);

endmodule

// File: rtl/lbist_patgen.sv
module lbist_patgen
    import lbist_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int FRAME_LEN = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   active,
    input  cfg_t                   cfg,
    output logic [LANES*SYM_W-1:0] tx_data,
    output logic                   frame_last
);
    localparam int FW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [PRBS_W-1:0] SEED = '1;

    logic [FW-1:0]     sym_idx;
    logic [SYM_W-1:0]  inc_cnt;
    logic [2:0]        tab_idx;
    logic [PRBS_W-1:0] lfsr;
    logic [SYM_W-1:0]  raw, sym;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sym_idx <= '0;
            inc_cnt <= '0;
            tab_idx <= '0;
            lfsr    <= SEED;
        end else if (active) begin
            sym_idx <= frame_last ? '0 : sym_idx + 1'b1;
            inc_cnt <= inc_cnt + 1'b1;
            tab_idx <= tab_idx + 1'b1;
            lfsr    <= prbs_adv(lfsr);
        end
    end

    always_comb begin
        case (cfg.pat)
            PAT_INC:  raw = inc_cnt;
            PAT_TABA: raw = tab_a(tab_idx);
            PAT_TABB: raw = tab_b(tab_idx);
            default:  raw = prbs_sym(lfsr);
        endcase
        sym = cfg.wide ? raw : {2'b00, raw[7:0]};
    end

    assign frame_last = active && (sym_idx == FW'(FRAME_LEN - 1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tx_data[g*SYM_W +: SYM_W] = active ? sym : '0;
    end

    p_narrow_top_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg.wide |-> (tx_data[SYM_W-1 -: 2] == 2'b00));

endmodule

// File: rtl/lbist_lanechk.sv
module lbist_lanechk
    import lbist_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             active,
    input  logic             last,
    input  logic             wide,
    input  logic [SYM_W-1:0] exp_sym,
    input  logic [SYM_W-1:0] rx_sym,
    output logic [CNT_W-1:0] frm_cnt,
    output logic [CNT_W-1:0] err_cnt
);
    logic bad_acc, mism;

    assign mism = active && (wide ? (rx_sym != exp_sym) : (rx_sym[7:0] != exp_sym[7:0]));

    always_ff @(posedge clk) begin
        if (rst || clr)  bad_acc <= 1'b0;
        else if (active) bad_acc <= last ? 1'b0 : (bad_acc | mism);
    end

    lbist_satcnt #(.W(CNT_W)) u_frm (
        .clk(clk), .rst(rst), .clr(clr), .inc(last), .q(frm_cnt));

    lbist_satcnt #(.W(CNT_W)) u_err (
        .clk(clk), .rst(rst), .clr(clr), .inc(last && (bad_acc || mism)), .q(err_cnt));

    p_err_bound_r7: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= frm_cnt);

endmodule

// File: rtl/lane_bist_ctrl.sv
module lane_bist_ctrl
    import lbist_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int CNT_W     = 16,
    parameter int FRAME_LEN = 8,
    parameter int DRAIN_CYC = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    output logic [LANES*SYM_W-1:0] tx_data,
    input  logic [LANES*SYM_W-1:0] rx_data
);
    localparam int A_TX  = 1;
    localparam int A_FRM = 2;
    localparam int A_ERR = 2 + LANES;

    cfg_t              cfg;
    logic              active, clr, frame_last;
    logic [REG_W-1:0]  ctrl_rd;
    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  frm_cnt [LANES];
    logic [CNT_W-1:0]  err_cnt [LANES];

    lbist_regs #(.ADDR_W(ADDR_W), .DRAIN_CYC(DRAIN_CYC)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg(cfg), .active(active), .clr(clr),
        .ctrl_rd(ctrl_rd));

    lbist_patgen #(.LANES(LANES), .FRAME_LEN(FRAME_LEN)) u_gen (
        .clk(clk), .rst(rst), .clr(clr), .active(active), .cfg(cfg),
        .tx_data(tx_data), .frame_last(frame_last));

    lbist_satcnt #(.W(CNT_W)) u_txcnt (
        .clk(clk), .rst(rst), .clr(clr), .inc(frame_last), .q(tx_cnt));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        lbist_lanechk #(.CNT_W(CNT_W)) u_chk (
            .clk(clk), .rst(rst), .clr(clr), .active(active), .last(frame_last),
            .wide(cfg.wide), .exp_sym(tx_data[g*SYM_W +: SYM_W]),
            .rx_sym(rx_data[g*SYM_W +: SYM_W]),
            .frm_cnt(frm_cnt[g]), .err_cnt(err_cnt[g]));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0)             reg_rdata = ctrl_rd;
        if (reg_addr == ADDR_W'(A_TX))  reg_rdata = REG_W'(tx_cnt);
        for (int i = 0; i < LANES; i++) begin
            if (reg_addr == ADDR_W'(A_FRM + i)) reg_rdata = REG_W'(frm_cnt[i]);
            if (reg_addr == ADDR_W'(A_ERR + i)) reg_rdata = REG_W'(err_cnt[i]);
        end
    end

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !active |-> (tx_data == '0));

endmodule

// File: tb/test_lane_bist_ctrl.sv
module test_lane_bist_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LN = 4;
    localparam int SW = 10;

    localparam logic [15:0] EN    = 16'h2000;
    localparam logic [15:0] STOP  = 16'h4000;
    localparam logic [15:0] START = 16'h8000;
    localparam logic [15:0] WIDE  = 16'h1000;
    localparam logic [15:0] P_INC = 16'h0000;
    localparam logic [15:0] P_TA  = 16'h0400;
    localparam logic [15:0] P_RND = 16'h0C00;

    logic clk = 0, rst = 1;
    logic reg_wr = 0;
    logic [3:0] reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic [LN*SW-1:0] tx_data, rx_data, flip = '0;
    int nchk = 0, nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rx_data = tx_data ^ flip;

    lane_bist_ctrl #(.CNT_W(6)) i_lane_bist_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_data(tx_data), .rx_data(rx_data));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic arm(input logic [15:0] c);
        wr(0, c);
        wr(0, c | EN);
    endtask

    // stop write, then wait out the 8-cycle drain
    task automatic halt(input logic [15:0] c);
        wr(0, c | EN | STOP);
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [SW-1:0] ref_prbs(input int idx);
        logic [6:0] s;
        logic [SW-1:0] o;
        logic nb;
        s = 7'h7F;
        o = '0;
        for (int n = 0; n <= idx; n++) begin
            for (int k = 0; k < SW; k++) begin
                nb = s[6] ^ s[5];
                o[SW-1-k] = nb;
                s = {s[5:0], nb};
            end
        end
        return o;
    endfunction

    task automatic t_reset;
        logic [15:0] d;
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], d);
            check("R6 reset value", d, 0);
        end
        check("R12 idle tx at reset", tx_data, 0);
    endtask

    task automatic t_fields;
        logic [15:0] d;
        wr(0, 16'h3C00); rd(0, d); check("R1 all config fields", d, 16'h3C00);
        wr(0, 16'h0400); rd(0, d); check("R1 type only", d, 16'h0400);
        wr(0, 16'h0000);
    endtask

    task automatic t_start_no_en;
        logic [15:0] d;
        wr(0, EN | START);
        rd(0, d); check("R2 start ignored, enable stored", d, EN);
        repeat (20) @(negedge clk);
        rd(1, d); check("R2 no frames sent", d, 0);
        check("R2 outputs quiet", tx_data, 0);
        wr(0, 0);
    endtask

    task automatic t_stop_timing;
        logic [15:0] d;
        arm(WIDE);
        wr(0, WIDE | EN | START);
        rd(0, d); check("R3 start bit set", d[15], 1);
        repeat (5) @(negedge clk);
        wr(0, WIDE | EN | STOP);
        rd(0, d); check("R4 stop reads 1 after write", d[14], 1);
        check("R4 start cleared by stop", d[15], 0);
        repeat (7) @(negedge clk);
        rd(0, d); check("R4 stop still 1 at drain end", d[14], 1);
        @(negedge clk);
        rd(0, d); check("R4 stop self-cleared", d[14], 0);
        rd(1, d); check("R5 drain frame counted", d, 1);
    endtask

    task automatic t_err_lane;
        logic [15:0] d;
        arm(WIDE | P_TA);
        wr(0, WIDE | P_TA | EN | START);
        repeat (10) @(negedge clk);
        flip[2*SW] = 1'b1;
        @(negedge clk);
        flip = '0;
        repeat (19) @(negedge clk);
        halt(WIDE | P_TA);
        rd(1, d); check("R5 tx frames", d, 5);
        for (int l = 0; l < LN; l++) begin
            rd(4'(2 + l), d); check("R6 rx frames lane", d, 5);
            rd(4'(6 + l), d); check("R7 errors lane", d, (l == 2) ? 1 : 0);
        end
        for (int a = 10; a < 16; a++) begin
            rd(a[3:0], d); check("R6 unused address", d, 0);
        end
    endtask

    task automatic t_narrow;
        logic [15:0] d;
        arm(P_INC);
        flip[SW + 9] = 1'b1;
        wr(0, P_INC | EN | START);
        rd(0, d); check("R3 previous errors cleared", d[15], 1);
        check("R10 first symbol", tx_data[SW-1:0], 0);
        @(negedge clk);
        check("R10 second symbol", tx_data[SW-1:0], 1);
        check("R10 lane3 matches lane0", tx_data[4*SW-1 -: SW], tx_data[SW-1:0]);
        check("R8 top bits zero", tx_data[9:8], 0);
        repeat (29) @(negedge clk);
        halt(P_INC);
        flip = '0;
        rd(7, d); check("R8 bit 9 not compared lane1", d, 0);
        rd(8, d); check("R3 lane2 errors cleared at start", d, 0);
        rd(3, d); check("R8 lane1 frames", d, 5);
    endtask

    task automatic t_prbs;
        arm(WIDE | P_RND);
        wr(0, WIDE | P_RND | EN | START);
        check("R11 prbs symbol 0", tx_data[SW-1:0], ref_prbs(0));
        @(negedge clk);
        check("R11 prbs symbol 1", tx_data[2*SW-1 -: SW], ref_prbs(1));
        @(negedge clk);
        check("R11 prbs symbol 2", tx_data[SW-1:0], ref_prbs(2));
        halt(WIDE | P_RND);
    endtask

    task automatic t_sat;
        logic [15:0] d;
        arm(WIDE);
        wr(0, WIDE | EN | START);
        repeat (600) @(negedge clk);
        halt(WIDE);
        rd(1, d); check("R9 tx saturates", d, 63);
        rd(5, d); check("R9 rx saturates lane3", d, 63);
        rd(9, d); check("R9 errors stay zero", d, 0);
    endtask

    task automatic t_disable;
        logic [15:0] d, c1;
        arm(WIDE);
        wr(0, WIDE | EN | START);
        repeat (20) @(negedge clk);
        wr(0, WIDE);
        rd(0, d); check("R12 ctrl after disable", d, WIDE);
        rd(1, c1); check("R12 frames at disable", c1, 2);
        check("R12 outputs quiet", tx_data, 0);
        repeat (20) @(negedge clk);
        rd(1, d); check("R12 counters frozen", d, c1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_fields;
        t_start_no_en;
        t_stop_timing;
        t_err_lane;
        t_narrow;
        t_prbs;
        t_sat;
        t_disable;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule